// File: doc/BRIEF.md
# Task-keyed paging memory mapper

This block sits between an 8-bit processor with a 16-bit address bus and a 24-bit physical memory system. It splits the virtual space into 2 KiB pages and keeps a page table for each of 32 tasks. For every bus cycle it produces a 24-bit physical address and a write-protect flag. The upper 13 physical bits come from the table entry of the running task. The low 11 bits pass through unchanged.

Software reaches the tables through a 128-byte register window on the 8-bit data bus. Up to eight copies of the block can share one bus. Each copy holds a 3-bit key value of its own. A copy translates only while the running-task key names it, and it answers table accesses only while the selection key names it. A copy that is not named drives zeros on its address and protect outputs, so the outputs of all copies can be ORed together. Table updates require a supervisor bit. That bit is set only on interrupt entry, which the block sees either on its acknowledge input or as a run of back-to-back write cycles.

Every clock edge is one bus cycle. `rw_n` low marks a write cycle.

Top module: `task_page_mapper`

## Requirements
- R1: After a synchronous reset, the supervisor bit, the selection key, the running-task key, the key value and every table entry are zero.
- R2: While running-key bits 7..5 equal the key value, `padr_o[10:0]` equals `adr[10:0]`. `padr_o[23:11]` and `wp_o` then come from the entry for page `adr[15:11]` of task running-key bits 4..0.
- R3: While running-key bits 7..5 differ from the key value, `padr_o` and `wp_o` are zero.
- R4: Window offset 2p holds page p's protect flag in bit 7 and physical bits 23..19 in bits 4..0. Bits 6..5 of that byte read 0 and are not stored. Offset 2p+1 holds physical bits 18..11. The window shows the task in selection-key bits 4..0.
- R5: Table bytes and the key value register are read and written only while selection-key bits 7..5 equal the key value. Otherwise reads return 0x00 and writes are ignored. Writes to the supervisor, selection-key and running-key registers do not need this match.
- R6: A register write takes effect only if the supervisor bit was 1 before that cycle.
- R7: A cycle with `inta` high sets the supervisor bit, which reads back at offset 0x48 bit 0. A write of bit 0 = 0 to offset 0x48 clears it. The selection key is at offset 0x4A and the running key at offset 0x4B.
- R8: The IRQ_WRITES-th consecutive write cycle (default 7, at any address) sets the supervisor bit. A read cycle restarts the run. A set from either source wins over a clear in the same cycle.
- R9: While `dma` is high the window neither reads nor writes, `dbo` is 0x00, and the consecutive-write run neither advances nor restarts.
- R10: Offsets 0x4C..0x7F, 0x49, 0x47..0x40 other than this copy's own slot, and any address outside the 128-byte window at BASE_ADDR (default 0xF800) read as 0x00.
- R11: The key value register sits at offset 0x40 + `inst_num`. Its 3 bits live in bits 2..0, and bits 7..3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| inst_num | input | 3 | Number of this copy on the shared bus |
| dma | input | 1 | A DMA cycle owns the bus |
| rw_n | input | 1 | 1 = read cycle, 0 = write cycle |
| dbi | input | 8 | Write data from the processor |
| dbo | output | 8 | Read data, 0x00 when not addressed |
| adr | input | 16 | Virtual address |
| padr_o | output | 24 | Physical address, zero when not keyed |
| wp_o | output | 1 | Write protect of the current page, zero when not keyed |
| inta | input | 1 | Interrupt acknowledge cycle |

## Verification
Interrupt entry and a register write can fall in the same cycle. This happens when `inta` is raised, or a write run reaches its limit, on the very cycle that writes 0 to the supervisor register. The bench arranges both: an acknowledge raised during the clearing write, and six writes followed by a clearing write as the seventh. It expects the bit still set on the following read. It also checks that a table write issued on the cycle that first sets the bit is dropped, because the gate uses the bit's earlier value. A behavioural model in the bench tracks both paths through directed and random cycles.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
    localparam int VA_W     = 16;
    localparam int PA_W     = 24;
    localparam int PAGE_W   = 11;
    localparam int FRAME_W  = PA_W - PAGE_W;   // 13
    localparam int PIDX_W   = VA_W - PAGE_W;   // 5
    localparam int TASK_W   = 5;
    localparam int KEY_W    = 3;
    localparam int WIN_W    = 7;
    localparam int N_ENTRY  = (1 << TASK_W) * (1 << PIDX_W);
    localparam int EIDX_W   = TASK_W + PIDX_W;

    localparam logic [WIN_W-1:0] OFF_SUP   = 7'h48;
    localparam logic [WIN_W-1:0] OFF_SEL   = 7'h4A;
    localparam logic [WIN_W-1:0] OFF_RUN   = 7'h4B;
    localparam logic [3:0]       KV_SLOT_HI = 4'b1000;

    typedef struct packed {
        logic               wp;
        logic [FRAME_W-1:0] frame;
    } tpm_entry_t;

    typedef struct packed {
        logic [KEY_W-1:0]  owner;
        logic [TASK_W-1:0] task_id;
    } tpm_key_t;

    function automatic logic [7:0] entry_byte(tpm_entry_t e, logic odd);
        if (odd) return e.frame[7:0];
        return {e.wp, 2'b00, e.frame[FRAME_W-1:8]};
    endfunction

    function automatic tpm_entry_t entry_merge(tpm_entry_t e, logic odd, logic [7:0] d);
        tpm_entry_t r = e;
        if (odd) r.frame[7:0] = d;
        else begin
            r.wp = d[7];
            r.frame[FRAME_W-1:8] = d[4:0];
        end
        return r;
    endfunction
endpackage

// File: rtl/tpm_irq_detect.sv
module tpm_irq_detect
    import tpm_pkg::*;
#(
    parameter int RUN_LEN = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic dma,
    input  logic rw_n,
    input  logic inta,
    output logic irq_entry
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);
    localparam logic [CNT_W-1:0] SAT  = CNT_W'(RUN_LEN);

    logic [CNT_W-1:0] run_q;
    logic             run_hit;

    assign run_hit   = !dma && !rw_n && (run_q == LAST);
    assign irq_entry = inta || run_hit;

    always_ff @(posedge clk) begin
        if (rst) run_q <= '0;
        else if (!dma) begin
            if (rw_n)            run_q <= '0;
            else if (run_q != SAT) run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/tpm_map_store.sv
module tpm_map_store
    import tpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [EIDX_W-1:0] wr_idx,
    input  logic              wr_odd,
    input  logic [7:0]        wr_data,
    input  logic [EIDX_W-1:0] win_idx,
    output tpm_entry_t        win_entry,
    input  logic [EIDX_W-1:0] xl_idx,
    output tpm_entry_t        xl_entry
);
    tpm_entry_t mem [N_ENTRY];

    assign win_entry = mem[win_idx];
    assign xl_entry  = mem[xl_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENTRY; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= entry_merge(mem[wr_idx], wr_odd, wr_data);
        end
    end
endmodule

// File: rtl/tpm_translate.sv
module tpm_translate
    import tpm_pkg::*;
(
    input  tpm_key_t         run_key,
    input  logic [KEY_W-1:0] kv,
    input  logic [VA_W-1:0]  vaddr,
    input  tpm_entry_t       entry,
    output logic [PA_W-1:0]  paddr,
    output logic             wp
);
    logic live;
    assign live  = (run_key.owner == kv);
    assign paddr = live ? {entry.frame, vaddr[PAGE_W-1:0]} : '0;
    assign wp    = live & entry.wp;
endmodule

// File: rtl/task_page_mapper.sv
module task_page_mapper
    import tpm_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR  = 16'hF800,
    parameter int          IRQ_WRITES = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  inst_num,
    input  logic        dma,
    input  logic        rw_n,
    input  logic [7:0]  dbi,
    output logic [7:0]  dbo,
    input  logic [15:0] adr,
    output logic [23:0] padr_o,
    output logic        wp_o,
    input  logic        inta
);
    tpm_key_t         acc_key, op_key;
    logic [KEY_W-1:0] kv_q;
    logic             s_q;
    logic             irq_entry;

    logic             in_win, bus_on, ak_ok, wr_cyc;
    logic [WIN_W-1:0] off;
    logic             tbl_wr, kv_wr, sup_wr, sel_wr, run_wr;
    logic [WIN_W-1:0] kv_off;
    tpm_entry_t       win_entry, xl_entry;

    assign off    = adr[WIN_W-1:0];
    assign kv_off = {KV_SLOT_HI, inst_num};
    assign in_win = (adr[VA_W-1:WIN_W] == BASE_ADDR[VA_W-1:WIN_W]);
    assign bus_on = in_win && !dma;
    assign ak_ok  = (acc_key.owner == kv_q);
    assign wr_cyc = bus_on && !rw_n && s_q;

    assign tbl_wr = wr_cyc && ak_ok && !off[6];
    assign kv_wr  = wr_cyc && ak_ok && (off == kv_off);
    assign sup_wr = wr_cyc && (off == OFF_SUP);
    assign sel_wr = wr_cyc && (off == OFF_SEL);
    assign run_wr = wr_cyc && (off == OFF_RUN);

    tpm_irq_detect #(.RUN_LEN(IRQ_WRITES)) u_irq (
        .clk(clk), .rst(rst), .dma(dma), .rw_n(rw_n), .inta(inta),
        .irq_entry(irq_entry)
    );

    tpm_map_store u_store (
        .clk(clk), .rst(rst),
        .wr_en(tbl_wr),
        .wr_idx({acc_key.task_id, off[5:1]}),
        .wr_odd(off[0]),
        .wr_data(dbi),
        .win_idx({acc_key.task_id, off[5:1]}),
        .win_entry(win_entry),
        .xl_idx({op_key.task_id, adr[VA_W-1:PAGE_W]}),
        .xl_entry(xl_entry)
    );

    tpm_translate u_xl (
        .run_key(op_key), .kv(kv_q), .vaddr(adr), .entry(xl_entry),
        .paddr(padr_o), .wp(wp_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_key <= '0;
            op_key  <= '0;
            kv_q    <= '0;
            s_q     <= 1'b0;
        end else begin
            if (sel_wr) acc_key <= tpm_key_t'(dbi);
            if (run_wr) op_key  <= tpm_key_t'(dbi);
            if (kv_wr)  kv_q    <= dbi[KEY_W-1:0];
            if (irq_entry)   s_q <= 1'b1;
            else if (sup_wr) s_q <= dbi[0];
        end
    end

    always_comb begin
        dbo = 8'h00;
        if (bus_on && rw_n && ak_ok) begin
            if (!off[6])                dbo = entry_byte(win_entry, off[0]);
            else if (off == kv_off)     dbo = {5'b0, kv_q};
            else if (off == OFF_SUP)    dbo = {7'b0, s_q};
            else if (off == OFF_SEL)    dbo = acc_key;
            else if (off == OFF_RUN)    dbo = op_key;
        end
    end
endmodule

// File: rtl/tpm_checker.sv
module tpm_checker (
    input logic        clk,
    input logic        rst,
    input logic        inta,
    input logic        dma,
    input logic        rw_n,
    input logic [15:0] adr,
    input logic [7:0]  dbo,
    input logic [23:0] padr_o,
    input logic        wp_o,
    input logic        s_q,
    input logic [7:0]  acc_key,
    input logic [7:0]  op_key,
    input logic [2:0]  kv_q,
    input logic        in_win
);
    a_r7_inta_sets_sup: assert property (@(posedge clk) disable iff (rst)
        inta |=> s_q);

    a_r6_keys_frozen_without_sup: assert property (@(posedge clk) disable iff (rst)
        !s_q |=> ($stable(acc_key) && $stable(op_key) && $stable(kv_q)));

    a_r3_unkeyed_outputs_zero: assert property (@(posedge clk) disable iff (rst)
        (op_key[7:5] != kv_q) |-> (padr_o == 24'h0 && !wp_o));

    a_r2_offset_passes: assert property (@(posedge clk) disable iff (rst)
        (op_key[7:5] == kv_q) |-> (padr_o[10:0] == adr[10:0]));

    a_r9_dma_reads_zero: assert property (@(posedge clk) disable iff (rst)
        dma |-> (dbo == 8'h00));

    a_r5_unselected_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (acc_key[7:5] != kv_q) |-> (dbo == 8'h00));

    a_r10_outside_window_zero: assert property (@(posedge clk) disable iff (rst)
        !in_win |-> (dbo == 8'h00));

    a_r6_write_cycle_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !rw_n |-> (dbo == 8'h00));
endmodule

bind task_page_mapper tpm_checker u_tpm_checker (
    .clk(clk), .rst(rst), .inta(inta), .dma(dma), .rw_n(rw_n), .adr(adr),
    .dbo(dbo), .padr_o(padr_o), .wp_o(wp_o), .s_q(s_q),
    .acc_key(acc_key), .op_key(op_key), .kv_q(kv_q), .in_win(in_win)
);

// File: tb/test_task_page_mapper.sv
module test_task_page_mapper;
    localparam int BASE = 'hF800;
    localparam int NRUN = 7;
    localparam logic [2:0] INST = 3'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dma = 1'b0, rw_n = 1'b1, inta = 1'b0;
    logic [7:0]  dbi = 8'h00;
    logic [15:0] adr = 16'h0000;
    logic [7:0]  dbo;
    logic [23:0] padr_o;
    logic        wp_o;

    int errors = 0, checks = 0, cycles = 0;
    bit done = 0;

    // behavioural reference state
    int mpa [1024];
    int mwp [1024];
    int m_kv, m_s, m_ak, m_ok, m_run;

    always #10 clk = ~clk;   // 50 MHz

    task_page_mapper i_task_page_mapper (
        .clk(clk), .rst(rst), .inst_num(INST), .dma(dma), .rw_n(rw_n),
        .dbi(dbi), .dbo(dbo), .adr(adr), .padr_o(padr_o), .wp_o(wp_o),
        .inta(inta)
    );

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                errors++;
                $display("FAIL watchdog: run did not end, got %0d cycles expected < 150000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks + 1);
                $finish;
            end
        end
    end

    function automatic int model_dbo(int rwn, int a, int dm);
        int off;
        int idx;
        if (!rwn || dm || ((a >> 7) != (BASE >> 7)) || ((m_ak >> 5) != m_kv)) return 0;
        off = a & 127;
        if (off < 64) begin
            idx = (m_ak & 31) * 32 + (off >> 1);
            if (off & 1) return mpa[idx] & 255;
            return (mwp[idx] << 7) | (mpa[idx] >> 8);
        end
        if (off == 64 + INST) return m_kv;
        if (off == 'h48) return m_s;
        if (off == 'h4A) return m_ak;
        if (off == 'h4B) return m_ok;
        return 0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 1024; i++) begin mpa[i] = 0; mwp[i] = 0; end
        m_kv = 0; m_s = 0; m_ak = 0; m_ok = 0; m_run = 0;
    endtask

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h (adr-cycle %0d)", tag, got, exp, cycles);
        end
    endtask

    // one bus cycle: drive, compare mid-cycle, advance model, cross the edge
    task automatic step(int rwn, int a, int d, int dm, int ia, string tag);
        int exp_pa, exp_wp, idx, off, irq, wr, ak_ok;
        rw_n = rwn[0]; adr = a[15:0]; dbi = d[7:0]; dma = dm[0]; inta = ia[0];
        #2;
        if ((m_ok >> 5) == m_kv) begin
            idx = (m_ok & 31) * 32 + (a >> 11);
            exp_pa = (mpa[idx] << 11) | (a & 2047);
            exp_wp = mwp[idx];
        end else begin
            exp_pa = 0; exp_wp = 0;
        end
        check({tag, " dbo"}, int'(dbo), model_dbo(rwn, a, dm));
        check({tag, " padr"}, int'(padr_o), exp_pa);
        check({tag, " wp"}, int'(wp_o), exp_wp);
        // next state
        irq = ia || (!dm && !rwn && m_run == NRUN - 1);
        off = a & 127;
        ak_ok = ((m_ak >> 5) == m_kv);
        wr = !rwn && !dm && ((a >> 7) == (BASE >> 7)) && m_s;
        if (wr && ak_ok && off < 64) begin
            idx = (m_ak & 31) * 32 + (off >> 1);
            if (off & 1) mpa[idx] = (mpa[idx] & 'h1F00) | d;
            else begin
                mwp[idx] = (d >> 7) & 1;
                mpa[idx] = (mpa[idx] & 'hFF) | ((d & 31) << 8);
            end
        end
        if (wr && ak_ok && off == 64 + INST) m_kv = d & 7;
        if (wr && off == 'h4A) m_ak = d;
        if (wr && off == 'h4B) m_ok = d;
        if (irq) m_s = 1;
        else if (wr && off == 'h48) m_s = d & 1;
        if (!dm) m_run = rwn ? 0 : ((m_run < NRUN) ? m_run + 1 : m_run);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(int a, string tag);  step(1, a, 0, 0, 0, tag); endtask
    task automatic wr(int a, int d, string tag); step(0, a, d, 0, 0, tag); endtask

    initial begin
        model_reset();
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        rd(BASE + 'h00, "R1 table");
        rd(BASE + 'h48, "R1 sup");
        rd(BASE + 'h4A, "R1 selkey");
        rd(BASE + 'h43, "R1 kv");
        rd('h3456, "R1 translate");

        // R6: writes ignored while supervisor bit clear
        wr(BASE + 'h00, 'h9F, "R6 write");
        rd(BASE + 'h00, "R6 readback");
        wr(BASE + 'h4B, 'h05, "R6 runkey");
        rd(BASE + 'h4B, "R6 runkey readback");

        // R7: acknowledge sets supervisor bit
        step(1, 'h0100, 0, 0, 1, "R7 inta");
        rd(BASE + 'h48, "R7 sup set");

        // R4: table byte layout, task 0 page 5
        wr(BASE + 'h0A, 'hFF, "R4 even");
        rd(BASE + 'h0A, "R4 even readback");
        wr(BASE + 'h0B, 'h5A, "R4 odd");
        rd(BASE + 'h0B, "R4 odd readback");
        // R2: translate through task 0 page 5
        rd('h2ABC, "R2 page5");
        rd('h2FFF, "R2 page5 top");
        rd('h3000, "R2 page6");

        // R4/R2: task 7 via selection key
        wr(BASE + 'h4A, 'h07, "R7 selkey");
        rd(BASE + 'h4A, "R7 selkey readback");
        wr(BASE + 'h00, 'h13, "R4 t7 even");
        rd(BASE + 'h01, "R4 t7 gap");
        wr(BASE + 'h01, 'hC4, "R4 t7 odd");
        rd(BASE + 'h00, "R4 t7 even readback");
        wr(BASE + 'h4B, 'h07, "R7 runkey");
        rd('h0123, "R2 task7 page0");
        rd('h2ABC, "R2 task7 page5 empty");

        // R11 / R5 / R3: move key value
        wr(BASE + 'h43, 'hFA, "R11 kv write");
        rd(BASE + 'h00, "R5 unselected read");
        rd('h0123, "R3 unkeyed");
        wr(BASE + 'h00, 'h11, "R5 unselected write");
        wr(BASE + 'h4A, 'h47, "R5 broadcast selkey");
        rd(BASE + 'h43, "R11 kv readback");
        rd(BASE + 'h00, "R5 unchanged entry");
        wr(BASE + 'h4B, 'h47, "R5 broadcast runkey");
        rd('h0123, "R2 rekeyed");

        // R10: undefined and foreign offsets
        rd(BASE + 'h40, "R10 foreign kv");
        rd(BASE + 'h47, "R10 foreign kv7");
        rd(BASE + 'h49, "R10 gap");
        rd(BASE + 'h4C, "R10 undefined");
        rd(BASE + 'h7F, "R10 undefined top");
        rd('h1234, "R10 outside");
        rd(BASE - 1, "R10 below window");

        // R9: DMA cycles
        step(1, BASE + 'h00, 0, 1, 0, "R9 dma read");
        step(0, BASE + 'h00, 'h00, 1, 0, "R9 dma write");
        rd(BASE + 'h00, "R9 entry kept");

        // R8: write-run detection
        wr(BASE + 'h48, 'h00, "R7 clear sup");
        rd(BASE + 'h48, "R7 sup cleared");
        for (int i = 0; i < 6; i++) wr('h0000, i, "R8 run a");
        rd(BASE + 'h48, "R8 six writes no set");
        for (int i = 0; i < 4; i++) wr('h0000, i, "R8 run b");
        step(0, 'h0000, 0, 1, 0, "R9 dma holds run");
        step(1, 'h0000, 0, 1, 0, "R9 dma read holds run");
        wr('h0000, 0, "R8 run b5");
        wr('h0000, 0, "R8 run b6");
        rd(BASE + 'h48, "R8 still clear");
        for (int i = 0; i < 7; i++) wr('h0000, i, "R8 run c");
        rd(BASE + 'h48, "R8 sup set by run");
        // set wins over clear, both sources
        step(0, BASE + 'h48, 'h00, 0, 1, "R8 inta vs clear");
        rd(BASE + 'h48, "R8 inta wins");
        for (int i = 0; i < 6; i++) wr('h0000, i, "R8 run d");
        wr(BASE + 'h48, 'h00, "R8 run vs clear");
        rd(BASE + 'h48, "R8 run wins");
        // table write on the cycle that first sets the bit is dropped
        wr(BASE + 'h48, 'h00, "R6 clear");
        rd(BASE + 'h02, "R6 pre");
        for (int i = 0; i < 6; i++) wr('h0000, i, "R6 run");
        wr(BASE + 'h02, 'h1E, "R6 write on set cycle");
        rd(BASE + 'h02, "R6 still empty");

        // random traffic against the model
        for (int n = 0; n < 6000; n++) begin
            int a, k;
            k = $urandom_range(0, 9);
            if (k < 6) a = BASE + $urandom_range(0, 127);
            else a = $urandom_range(0, 65535);
            step($urandom_range(0, 2) != 0 ? 1 : 0, a, $urandom_range(0, 255),
                 $urandom_range(0, 15) == 0 ? 1 : 0, $urandom_range(0, 40) == 0 ? 1 : 0,
                 "R2 R4 R5 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule